// File: doc/BRIEF.md
# Alternating Read/Write Pipelined SRAM Arbiter

This block lets two request streams share one pipelined synchronous SRAM whose bus needs no idle cycle between a read and a write. One stream is a queue of write requests, each holding an address and a data word. The other is a queue of read addresses. Both queues work in first-word-fall-through fashion: the head entry is visible whenever its valid flag is high, and a pop removes it. Data that is read back goes into a third queue, which the block fills through a push strobe.

A one-bit slot register flips on every clock, so read slots and write slots alternate without exception. In a read slot the SRAM address comes from the read queue. In a write slot it comes from the address field of the write entry, and the active-low write strobe is pulled low. When the queue that owns the slot is empty, the cycle becomes a dummy read whose result is thrown away. The SRAM returns or accepts data two clocks after the address. For that reason, the bus drive enable and the write data pass through a clocked delay line, and the read-data push strobe passes through a second one. The bus itself is split into drive data, drive enable and sampled input, and the pad buffer sits outside the block.

Top module: `zsa_share_arbiter`

## Requirements
- R1: While reset is asserted, the slot output reads 1 (read slot), the write strobe is high, and neither the bus drive enable nor the read-data push is asserted.
- R2: After reset, the slot output inverts on every clock. The first cycle out of reset is a read slot.
- R3: In a read slot the SRAM address equals the read-queue head. The read pop equals the read-queue valid flag, the write pop is 0 and the write strobe is high. The two pops are never high together.
- R4: In a write slot the SRAM address is bits [49:32] of the write entry, whose data occupies bits [31:0]. The write pop equals the write-queue valid flag, the write strobe is low exactly when that flag is high, and the read pop is 0.
- R5: A slot whose queue is empty pops nothing and leaves the write strobe high. Two cycles later it produces no read-data push and no bus drive.
- R6: The bus drive enable is high exactly two cycles after a write is issued. In that cycle the drive data equals the data field of that write. At all other times the drive enable is low.
- R7: The read-data push is high exactly two cycles after a read is issued. In that cycle the pushed data equals the word the SRAM presents on its input bus. At all other times the push is low.
- R8: Requests are served in issue order. A read issued after a write to the same address returns the written word, and a read issued before it returns the older word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SRAM-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wq_valid | input | 1 | Write-queue head is valid |
| wq_entry | input | 50 | Write-queue head: address [49:32], data [31:0] |
| wq_pop | output | 1 | Removes the write-queue head |
| rq_valid | input | 1 | Read-address queue head is valid |
| rq_addr | input | 18 | Read-address queue head |
| rq_pop | output | 1 | Removes the read-address queue head |
| rdf_push | output | 1 | Writes rdf_data into the read-data queue |
| rdf_data | output | 32 | Read word for the read-data queue |
| slot_rd | output | 1 | 1 in a read slot, 0 in a write slot |
| sram_addr | output | 18 | SRAM address |
| sram_we_n | output | 1 | SRAM write strobe, active low |
| sram_dq_out | output | 32 | Data to drive onto the SRAM bus |
| sram_dq_oe | output | 1 | Enable for the bus drive buffer |
| sram_dq_in | input | 32 | Data sampled from the SRAM bus |

## Verification
A slot register stuck or out of phase shows up at once: a pop or write strobe falls in the wrong slot, or the address follows the wrong queue. A wrong stage in either delay line shows up two cycles after the affected request. The bus is then driven in the wrong cycle or with another request's data, or a push arrives early, late or for a dummy read. The scoreboard catches this because each expectation carries the cycle it is due in. A data mix-up between requests appears the first time a later read returns that address. That is why the stimulus reads back addresses it has just written, within a few slots.

// File: rtl/zsa_pkg.sv
package zsa_pkg;

   // Slot kind held by the alternating slot register
   typedef enum logic {
      SLOT_WRITE = 1'b0,
      SLOT_READ  = 1'b1
   } slot_e;

   // Default geometry of the shared memory
   localparam int unsigned ZSA_ADDR_W  = 18;
   localparam int unsigned ZSA_DATA_W  = 32;
   localparam int unsigned ZSA_LATENCY = 2;

endpackage

// File: rtl/zsa_slot_toggle.sv
module zsa_slot_toggle
   import zsa_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   output slot_e slot_q
);

   // Strict alternation; reset lands on a read slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= SLOT_READ;
      end else if (slot_q == SLOT_READ) begin
         slot_q <= SLOT_WRITE;
      end else begin
         slot_q <= SLOT_READ;
      end
   end

endmodule

// File: rtl/zsa_issue.sv
module zsa_issue
   import zsa_pkg::*;
#(
   parameter int unsigned ADDR_W      = ZSA_ADDR_W,
   parameter int unsigned DATA_W      = ZSA_DATA_W,
   parameter bit          ADDR_IN_MSB = 1'b1,
   localparam int unsigned ENTRY_W    = ADDR_W + DATA_W
) (
   input  slot_e              slot,
   input  logic               wq_valid,
   input  logic [ENTRY_W-1:0] wq_entry,
   input  logic               rq_valid,
   input  logic [ADDR_W-1:0]  rq_addr,
   output logic [ADDR_W-1:0]  sram_addr,
   output logic               sram_we_n,
   output logic               wq_pop,
   output logic               rq_pop,
   output logic               wr_issue,
   output logic               rd_issue,
   output logic [DATA_W-1:0]  wr_data
);

   logic [ADDR_W-1:0] wr_addr;

   // Field layout of a write entry is a build-time option
   generate
      if (ADDR_IN_MSB) begin : g_addr_hi
         assign wr_addr = wq_entry[ENTRY_W-1:DATA_W];
         assign wr_data = wq_entry[DATA_W-1:0];
      end else begin : g_addr_lo
         assign wr_addr = wq_entry[ADDR_W-1:0];
         assign wr_data = wq_entry[ENTRY_W-1:ADDR_W];
      end
   endgenerate

   always_comb begin
      wq_pop    = 1'b0;
      rq_pop    = 1'b0;
      wr_issue  = 1'b0;
      rd_issue  = 1'b0;
      sram_we_n = 1'b1;
      if (slot == SLOT_READ) begin
         // Read slot: empty queue still reads, result is dropped
         sram_addr = rq_addr;
         rq_pop    = rq_valid;
         rd_issue  = rq_valid;
      end else begin
         // Write slot: empty queue turns into a dummy read
         sram_addr = wr_addr;
         wq_pop    = wq_valid;
         wr_issue  = wq_valid;
         sram_we_n = ~wq_valid;
      end
   end

endmodule

// File: rtl/zsa_delay_line.sv
module zsa_delay_line #(
   parameter int unsigned WIDTH = 1,
   parameter int unsigned DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (DEPTH == 0) begin : g_wire
         assign q = d;
      end else begin : g_regs
         logic [WIDTH-1:0] stage_q [DEPTH];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(DEPTH); i++) begin
                  stage_q[i] <= '0;
               end
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < int'(DEPTH); i++) begin
                  stage_q[i] <= stage_q[i-1];
               end
            end
         end

         assign q = stage_q[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/zsa_share_arbiter.sv
module zsa_share_arbiter
   import zsa_pkg::*;
#(
   parameter int unsigned ADDR_W      = ZSA_ADDR_W,
   parameter int unsigned DATA_W      = ZSA_DATA_W,
   parameter int unsigned LATENCY     = ZSA_LATENCY,
   parameter bit          ADDR_IN_MSB = 1'b1,
   localparam int unsigned ENTRY_W    = ADDR_W + DATA_W,
   localparam int unsigned WPIPE_W    = DATA_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wq_valid,
   input  logic [ENTRY_W-1:0] wq_entry,
   output logic               wq_pop,
   input  logic               rq_valid,
   input  logic [ADDR_W-1:0]  rq_addr,
   output logic               rq_pop,
   output logic               rdf_push,
   output logic [DATA_W-1:0]  rdf_data,
   output logic               slot_rd,
   output logic [ADDR_W-1:0]  sram_addr,
   output logic               sram_we_n,
   output logic [DATA_W-1:0]  sram_dq_out,
   output logic               sram_dq_oe,
   input  logic [DATA_W-1:0]  sram_dq_in
);

   generate
      if (LATENCY < 1) begin : g_bad_latency
         $error("zsa_share_arbiter: LATENCY must be at least 1");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("zsa_share_arbiter: widths must be non-zero");
      end
   endgenerate

   slot_e             slot_w;
   logic              wr_issue;
   logic              rd_issue;
   logic [DATA_W-1:0] wr_data;
   logic [WPIPE_W-1:0] wpipe_in;
   logic [WPIPE_W-1:0] wpipe_out;

   zsa_slot_toggle u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .slot_q (slot_w)
   );

   zsa_issue #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .ADDR_IN_MSB (ADDR_IN_MSB)
   ) u_issue (
      .slot      (slot_w),
      .wq_valid  (wq_valid),
      .wq_entry  (wq_entry),
      .rq_valid  (rq_valid),
      .rq_addr   (rq_addr),
      .sram_addr (sram_addr),
      .sram_we_n (sram_we_n),
      .wq_pop    (wq_pop),
      .rq_pop    (rq_pop),
      .wr_issue  (wr_issue),
      .rd_issue  (rd_issue),
      .wr_data   (wr_data)
   );

   // Drive enable and write word travel together; idle stages stay zero
   assign wpipe_in = {wr_issue, (wr_issue ? wr_data : {DATA_W{1'b0}})};

   zsa_delay_line #(
      .WIDTH (WPIPE_W),
      .DEPTH (LATENCY)
   ) u_wr_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (wpipe_in),
      .q     (wpipe_out)
   );

   zsa_delay_line #(
      .WIDTH (1),
      .DEPTH (LATENCY)
   ) u_rd_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rd_issue),
      .q     (rdf_push)
   );

   assign sram_dq_oe  = wpipe_out[WPIPE_W-1];
   assign sram_dq_out = wpipe_out[DATA_W-1:0];
   assign rdf_data    = sram_dq_in;
   assign slot_rd     = (slot_w == SLOT_READ);

endmodule

// File: rtl/zsa_share_checker.sv
module zsa_share_checker #(
   parameter int unsigned LATENCY = 2
) (
   input logic clk,
   input logic rst_n,
   input logic slot_rd,
   input logic wq_valid,
   input logic wq_pop,
   input logic rq_valid,
   input logic rq_pop,
   input logic sram_we_n,
   input logic sram_dq_oe,
   input logic rdf_push
);

   // Independent record of issued requests, one bit per cycle
   logic [LATENCY-1:0] wr_hist;
   logic [LATENCY-1:0] rd_hist;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_hist <= '0;
         rd_hist <= '0;
      end else begin
         wr_hist <= (wr_hist << 1) | LATENCY'(!sram_we_n);
         rd_hist <= (rd_hist << 1) | LATENCY'(rq_pop);
      end
   end

   AST_SLOT_ALT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (slot_rd != $past(slot_rd)));                          // R2

   AST_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(wq_pop && rq_pop));                                             // R3

   AST_RPOP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      rq_pop |-> (slot_rd && rq_valid));                                // R3

   AST_WE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (!slot_rd && wq_valid && wq_pop));                 // R4

   AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_rd && !wq_valid) |-> (sram_we_n && !wq_pop));              // R5

   AST_OE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe == wr_hist[LATENCY-1]);                                // R6

   AST_PUSH_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      rdf_push == rd_hist[LATENCY-1]);                                  // R7

endmodule

bind zsa_share_arbiter zsa_share_checker #(
   .LATENCY (LATENCY)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .slot_rd    (slot_rd),
   .wq_valid   (wq_valid),
   .wq_pop     (wq_pop),
   .rq_valid   (rq_valid),
   .rq_pop     (rq_pop),
   .sram_we_n  (sram_we_n),
   .sram_dq_oe (sram_dq_oe),
   .rdf_push   (rdf_push)
);

// File: tb/sim_zsa_share_arbiter.sv
`timescale 1ns/1ps
module sim_zsa_share_arbiter;

   localparam int AW = 18;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wq_valid = 1'b0;
   logic [AW+DW-1:0] wq_entry = '0;
   logic          wq_pop;
   logic          rq_valid = 1'b0;
   logic [AW-1:0] rq_addr = '0;
   logic          rq_pop;
   logic          rdf_push;
   logic [DW-1:0] rdf_data;
   logic          slot_rd;
   logic [AW-1:0] sram_addr;
   logic          sram_we_n;
   logic [DW-1:0] sram_dq_out;
   logic          sram_dq_oe;
   logic [DW-1:0] sram_dq_in = '0;

   zsa_share_arbiter u0 (
      .clk(clk), .rst_n(rst_n),
      .wq_valid(wq_valid), .wq_entry(wq_entry), .wq_pop(wq_pop),
      .rq_valid(rq_valid), .rq_addr(rq_addr), .rq_pop(rq_pop),
      .rdf_push(rdf_push), .rdf_data(rdf_data), .slot_rd(slot_rd),
      .sram_addr(sram_addr), .sram_we_n(sram_we_n),
      .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
      .sram_dq_in(sram_dq_in)
   );

   always #10 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit done    = 1'b0;

   // Request queues (first-word-fall-through stand-ins)
   logic [AW+DW-1:0] wq_q [$];
   logic [AW-1:0]    rq_q [$];
   // Scoreboard: expected items with the cycle they are due in
   int            exp_wr_due [$];
   logic [DW-1:0] exp_wr_dat [$];
   int            exp_rd_due [$];
   logic [DW-1:0] exp_rd_dat [$];
   // Reference contents in issue order, and the SRAM model contents
   logic [DW-1:0] ref_mem [int];
   logic [DW-1:0] sram_mem [int];
   // SRAM model pipeline: {valid write, address}
   bit            p1_we = 0, p2_we = 0;
   logic [AW-1:0] p1_a = '0, p2_a = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic push_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wq_q.push_back({a, d});
   endtask

   task automatic push_rd(input logic [AW-1:0] a);
      rq_q.push_back(a);
   endtask

   function automatic logic [DW-1:0] ref_rd(input logic [AW-1:0] a);
      return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
   endfunction

   // Monitor and SRAM model: observe at the falling edge, update after the rising edge
   bit            have_prev = 0;
   logic          prev_slot = 1'b0;
   bit            pop_w, pop_r, cur_we;
   logic [AW-1:0] cur_a;

   initial begin
      forever begin
         @(negedge clk);
         pop_w = 0;
         pop_r = 0;
         if (!rst_n) begin
            chk(slot_rd == 1'b1,   "R1", "slot in reset",      slot_rd, 1);
            chk(sram_we_n == 1'b1, "R1", "we_n in reset",      sram_we_n, 1);
            chk(sram_dq_oe == 1'b0,"R1", "drive en in reset",  sram_dq_oe, 0);
            chk(rdf_push == 1'b0,  "R1", "push in reset",      rdf_push, 0);
            have_prev = 0;
         end else begin
            if (!have_prev)
               chk(slot_rd == 1'b1, "R2", "first slot after reset", slot_rd, 1);
            else
               chk(slot_rd != prev_slot, "R2", "slot alternation", slot_rd, ~prev_slot);
            prev_slot = slot_rd;
            have_prev = 1;
            if (slot_rd) begin
               chk(rq_pop == rq_valid, "R3", "read pop", rq_pop, rq_valid);
               chk(!wq_pop && sram_we_n, "R3", "write activity in read slot", {wq_pop, sram_we_n}, 2'b01);
               if (rq_valid) chk(sram_addr == rq_addr, "R3", "read address", sram_addr, rq_addr);
               if (rq_pop) begin
                  exp_rd_due.push_back(cyc + 2);
                  exp_rd_dat.push_back(ref_rd(rq_addr));
                  pop_r = 1;
               end
            end else begin
               chk(wq_pop == wq_valid, "R4", "write pop", wq_pop, wq_valid);
               chk(!rq_pop, "R4", "read pop in write slot", rq_pop, 0);
               chk(sram_we_n == !wq_valid, "R5", "write strobe vs queue valid", sram_we_n, !wq_valid);
               if (wq_valid) chk(sram_addr == wq_entry[AW+DW-1:DW], "R4", "write address",
                                 sram_addr, wq_entry[AW+DW-1:DW]);
               if (wq_pop) begin
                  ref_mem[int'(wq_entry[AW+DW-1:DW])] = wq_entry[DW-1:0];
                  exp_wr_due.push_back(cyc + 2);
                  exp_wr_dat.push_back(wq_entry[DW-1:0]);
                  pop_w = 1;
               end
            end
            // R6: bus drive timing and data
            if (exp_wr_due.size() > 0 && exp_wr_due[0] == cyc) begin
               chk(sram_dq_oe == 1'b1, "R6", "drive enable due", sram_dq_oe, 1);
               chk(sram_dq_out == exp_wr_dat[0], "R6", "drive data", sram_dq_out, exp_wr_dat[0]);
               void'(exp_wr_due.pop_front());
               void'(exp_wr_dat.pop_front());
            end else begin
               chk(sram_dq_oe == 1'b0, "R6", "drive enable idle", sram_dq_oe, 0);
            end
            // R7/R8: read-data push timing and content; R5 no push for dummy reads
            if (exp_rd_due.size() > 0 && exp_rd_due[0] == cyc) begin
               chk(rdf_push == 1'b1, "R7", "push due", rdf_push, 1);
               chk(rdf_data == exp_rd_dat[0], "R8", "read data", rdf_data, exp_rd_dat[0]);
               void'(exp_rd_due.pop_front());
               void'(exp_rd_dat.pop_front());
            end else begin
               chk(rdf_push == 1'b0, "R5", "push without read", rdf_push, 0);
            end
            if (pop_w && wq_q.size() == 0) chk(0, "R4", "pop of empty write queue", 1, 0);
            if (pop_r && rq_q.size() == 0) chk(0, "R3", "pop of empty read queue", 1, 0);
         end
         // SRAM model: commit the write that reached the data phase
         if (p2_we) begin
            if (sram_dq_oe) sram_mem[int'(p2_a)] = sram_dq_out;
         end
         cur_we = !sram_we_n;
         cur_a  = sram_addr;

         @(posedge clk);
         #1;
         cyc++;
         if (pop_w && wq_q.size() > 0) void'(wq_q.pop_front());
         if (pop_r && rq_q.size() > 0) void'(rq_q.pop_front());
         p2_we = p1_we; p2_a = p1_a;
         p1_we = cur_we; p1_a = cur_a;
         if (!p2_we)
            sram_dq_in = sram_mem.exists(int'(p2_a)) ? sram_mem[int'(p2_a)] : '0;
         else
            sram_dq_in = 32'h5A5A_0000 ^ cyc;
         wq_valid = (wq_q.size() > 0);
         wq_entry = (wq_q.size() > 0) ? wq_q[0] : {AW+DW{1'b0}};
         rq_valid = (rq_q.size() > 0);
         rq_addr  = (rq_q.size() > 0) ? rq_q[0] : {AW{1'b0}};
      end
   end

   task automatic drain();
      int guard = 0;
      while ((wq_q.size() + rq_q.size() + exp_wr_due.size() + exp_rd_due.size()) != 0
             && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      repeat (4) @(negedge clk);
   endtask

   // Driver
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // Both queues empty: dummy slots only (R5)
      repeat (6) @(negedge clk);
      // Three reads and two writes waiting at once (R3, R4, R8)
      push_rd(18'd5); push_rd(18'd6); push_rd(18'd7);
      push_wr(18'd5, 32'h1111_AAAA); push_wr(18'd9, 32'h2222_BBBB);
      drain();
      push_rd(18'd9); push_rd(18'd5);
      drain();
      // Write burst with read slots idle, then read-back burst (R6, R7)
      for (int i = 0; i < 8; i++) push_wr(18'(100 + i), 32'hC000_0000 + i * 32'h0101);
      drain();
      for (int i = 0; i < 8; i++) push_rd(18'(107 - i));
      drain();
      // Read of an address just written in the neighbouring slot (R8)
      push_wr(18'h3FFFF, 32'hDEAD_0001);
      push_rd(18'h3FFFF);
      push_rd(18'h3FFFF);
      drain();
      // Random mix over a small address range with gaps
      for (int i = 0; i < 300; i++) begin
         if ($urandom_range(0, 1) == 0) push_wr(18'($urandom_range(0, 15)), $urandom);
         else                           push_rd(18'($urandom_range(0, 15)));
         if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 4)) @(negedge clk);
      end
      drain();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule